// File: doc/BRIEF.md
# Bidirectional Port Access Controller

This block is the control decoder for one side of a pair of FIFOs that carry data in opposite directions. The side has a single bidirectional data bus that serves two jobs: pushing words into the outgoing FIFO and presenting words popped from the incoming FIFO. An active-low select and a direction select choose what the bus does. Separate write and read enables then qualify each transfer. The write strobe is also qualified by the outgoing FIFO's space flag, and the read strobe by the incoming FIFO's data-available flag.

The bus output enable is purely combinational. It depends only on the select and the direction select, so the bus can change from driven to floating in the middle of a cycle. The strobes are also combinational, and the FIFOs consume them on the next rising clock edge.

The block also holds the two threshold offsets, almost-empty and almost-full, that the neighbouring flag comparators use. After a reset and before the first accepted write, the offsets can be loaded from the low bits of the bus with an active-low program request. Data writes are blocked for as long as that request is asserted.

Top module: `pac_port_ctrl`

## Requirements
- R1: `bus_oe` is 1, and the bus carries `rd_data`, exactly when `cs_n` is 0 and `wr_sel` is 0. In every other case the block leaves the bus floating. This is combinational and does not wait for a clock edge.
- R2: `wr_stb` is 1 exactly when `cs_n`=0, `wr_sel`=1, `wr_en`=1, `in_ready`=1 and `prog_n`=1. While it is 1, `wr_data` equals the value on the bus.
- R3: `rd_stb` is 1 exactly when `cs_n`=0, `wr_sel`=0, `rd_en`=1 and `out_ready`=1.
- R4: While `cs_n` is 1, `wr_stb`, `rd_stb` and `bus_oe` are all 0, whatever the other inputs are.
- R5: `wr_stb` and `rd_stb` are never 1 in the same cycle.
- R6: While `prog_n` is 0, `wr_stb` is 0, even if every other write condition is met.
- R7: After reset, both `ae_ofs` and `af_ofs` hold the default value OFS_DEFAULT (128).
- R8: The first rising edge with `prog_n`=0 while the program window is open loads bus bits [OFS_W-1:0] into both `ae_ofs` and `af_ofs`. Bus bits at OFS_W and above are ignored.
- R9: If `prog_n` stays 0 for the next edge, that edge loads bus bits [OFS_W-1:0] into `af_ofs` only. Any further edges with `prog_n` still 0 leave both offsets unchanged.
- R10: The program window closes on the first edge where `wr_stb` is 1. After that, `prog_n` has no effect on either offset until the next reset.
- R11: If `prog_n` returns to 1 for at least one edge and is then asserted again while the window is still open, the sequence starts over at the both-offsets step.
- R12: A later reset restores both offsets to the default and reopens the program window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Port select, active low |
| wr_sel | input | 1 | Direction select: 1 writes into the outgoing FIFO, 0 reads from the incoming FIFO |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| in_ready | input | 1 | Outgoing FIFO has space |
| out_ready | input | 1 | Incoming FIFO output holds valid data |
| prog_n | input | 1 | Offset program request, active low |
| rd_data | input | DATA_W | Word from the incoming FIFO output register |
| bus_io | inout | DATA_W | Shared bidirectional data bus |
| wr_stb | output | 1 | Push strobe to the outgoing FIFO |
| wr_data | output | DATA_W | Word to push, taken from the bus |
| rd_stb | output | 1 | Pop strobe to the incoming FIFO |
| bus_oe | output | 1 | Bus drive enable |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |

## Verification
The assertions assume that the outside world never drives the bus while the block itself is driving it. They also assume that the control inputs settle before each rising edge, so that a combinational strobe sampled at the edge matches the conditions present in that cycle. The stimulus changes every input only on the falling edge. It drives the bus from the bench only when `wr_sel` is 1, which guarantees the block is not driving at the same time. The bench sweeps every combination of the seven control inputs after the program window has closed, so that the sweep cannot disturb the offset state.

// File: rtl/pac_pkg.sv
package pac_pkg;

    // Default threshold offset used when nothing is programmed.
    localparam int PAC_OFS_DEFAULT = 128;

    // Port control pins gathered into one record.
    typedef struct packed {
        logic cs_n;
        logic wr_sel;
        logic wr_en;
        logic rd_en;
        logic in_ready;
        logic out_ready;
        logic prog_n;
    } port_ctl_t;

    // Decoded actions for the current cycle.
    typedef struct packed {
        logic push;
        logic pop;
        logic drive;
    } port_act_t;

    // Offset programming phase.
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_BOTH = 2'd1,
        PG_HOLD = 2'd2
    } pg_phase_e;

    function automatic port_act_t pac_decode_f(input port_ctl_t c);
        port_act_t a;
        logic      sel;
        sel     = ~c.cs_n;
        a.drive = sel & ~c.wr_sel;
        a.push  = sel & c.wr_sel & c.wr_en & c.in_ready & c.prog_n;
        a.pop   = sel & ~c.wr_sel & c.rd_en & c.out_ready;
        return a;
    endfunction

endpackage

// File: rtl/pac_decode.sv
module pac_decode
    import pac_pkg::*;
(
    input  port_ctl_t ctl,
    output port_act_t act
);
    always_comb begin
        act = pac_decode_f(ctl);
    end
endmodule

// File: rtl/pac_bus.sv
module pac_bus #(
    parameter int DATA_W = 18
) (
    input  logic              oe,
    input  logic [DATA_W-1:0] drv_data,
    inout  wire  [DATA_W-1:0] bus_io,
    output logic [DATA_W-1:0] bus_in
);
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            assign bus_io[gi] = oe ? drv_data[gi] : 1'bz;
        end
    endgenerate

    assign bus_in = bus_io;
endmodule

// File: rtl/pac_prog.sv
module pac_prog
    import pac_pkg::*;
#(
    parameter int OFS_W       = 8,
    parameter int OFS_DEFAULT = PAC_OFS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_n,
    input  logic             push,
    input  logic [OFS_W-1:0] load_val,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(OFS_DEFAULT);

    pg_phase_e phase;
    logic      window_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PG_IDLE;
            window_open <= 1'b1;
            ae_ofs      <= DEF_VAL;
            af_ofs      <= DEF_VAL;
        end else begin
            if (push) begin
                window_open <= 1'b0;
            end
            if (prog_n) begin
                phase <= PG_IDLE;
            end else if (window_open) begin
                case (phase)
                    PG_IDLE: begin
                        ae_ofs <= load_val;
                        af_ofs <= load_val;
                        phase  <= PG_BOTH;
                    end
                    PG_BOTH: begin
                        af_ofs <= load_val;
                        phase  <= PG_HOLD;
                    end
                    default: begin
                        phase <= PG_HOLD;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pac_port_ctrl.sv
module pac_port_ctrl
    import pac_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int OFS_W       = 8,
    parameter int OFS_DEFAULT = PAC_OFS_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              in_ready,
    input  logic              out_ready,
    input  logic              prog_n,
    input  logic [DATA_W-1:0] rd_data,
    inout  wire  [DATA_W-1:0] bus_io,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_stb,
    output logic              bus_oe,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs
);
    port_ctl_t         ctl;
    port_act_t         act;
    logic [DATA_W-1:0] bus_in;

    assign ctl = '{cs_n: cs_n, wr_sel: wr_sel, wr_en: wr_en, rd_en: rd_en,
                   in_ready: in_ready, out_ready: out_ready, prog_n: prog_n};

    pac_decode u_decode (
        .ctl (ctl),
        .act (act)
    );

    pac_bus #(.DATA_W(DATA_W)) u_bus (
        .oe       (act.drive),
        .drv_data (rd_data),
        .bus_io   (bus_io),
        .bus_in   (bus_in)
    );

    pac_prog #(.OFS_W(OFS_W), .OFS_DEFAULT(OFS_DEFAULT)) u_prog (
        .clk      (clk),
        .rst      (rst),
        .prog_n   (prog_n),
        .push     (act.push),
        .load_val (bus_in[OFS_W-1:0]),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs)
    );

    assign wr_stb  = act.push;
    assign rd_stb  = act.pop;
    assign bus_oe  = act.drive;
    assign wr_data = bus_in;
endmodule

// File: rtl/pac_port_ctrl_chk.sv
module pac_port_ctrl_chk #(
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             prog_n,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic             bus_oe,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs
);
    // R5: the two strobes never coincide
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));

    // R3: a pop only happens while the bus is being driven
    p_pop_drives_r3: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> bus_oe);

    // R4: a deselected port does nothing
    p_idle_desel_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!wr_stb && !rd_stb && !bus_oe));

    // R6: programming blocks pushes
    p_prog_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> !wr_stb);

    // R9: offsets change only on a programming edge
    p_ofs_hold_r9: assert property (@(posedge clk) disable iff (rst)
        prog_n |=> ($stable(ae_ofs) && $stable(af_ofs)));
endmodule

bind pac_port_ctrl pac_port_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .prog_n (prog_n),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .bus_oe (bus_oe),
    .ae_ofs (ae_ofs),
    .af_ofs (af_ofs)
);

// File: tb/tb_pac_port_ctrl.sv
`timescale 1ns/1ps
module tb_pac_port_ctrl;
    localparam int DW = 18;
    localparam int OW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, wr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic in_ready = 1'b0, out_ready = 1'b0, prog_n = 1'b1;
    logic [DW-1:0] rd_data = '0;
    logic [DW-1:0] tb_drv = '0;
    logic          tb_drv_en = 1'b0;
    wire  [DW-1:0] bus_w;
    logic          wr_stb, rd_stb, bus_oe;
    logic [DW-1:0] wr_data;
    logic [OW-1:0] ae_ofs, af_ofs;

    int n_chk = 0;
    int n_err = 0;

    assign bus_w = tb_drv_en ? tb_drv : 'z;

    always #2.5 clk = ~clk;

    pac_port_ctrl #(.DATA_W(DW), .OFS_W(OW)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_sel(wr_sel), .wr_en(wr_en),
        .rd_en(rd_en), .in_ready(in_ready), .out_ready(out_ready),
        .prog_n(prog_n), .rd_data(rd_data), .bus_io(bus_w),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .bus_oe(bus_oe), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R7 ae_ofs default", ae_ofs, 128);
        chk("R7 af_ofs default", af_ofs, 128);

        // Program first step with push conditions otherwise met
        @(negedge clk);
        cs_n = 0; wr_sel = 1; wr_en = 1; in_ready = 1; prog_n = 0;
        tb_drv = 18'h3FF05; tb_drv_en = 1;
        #1;
        chk("R6 push blocked by prog", wr_stb, 0);
        @(negedge clk);
        #1;
        chk("R8 ae_ofs first step", ae_ofs, 8'h05);
        chk("R8 af_ofs first step", af_ofs, 8'h05);
        tb_drv = 18'h2000A;
        @(negedge clk);
        #1;
        chk("R9 ae_ofs second step", ae_ofs, 8'h05);
        chk("R9 af_ofs second step", af_ofs, 8'h0A);
        tb_drv = 18'h00033;
        @(negedge clk);
        #1;
        chk("R9 ae_ofs third edge", ae_ofs, 8'h05);
        chk("R9 af_ofs third edge", af_ofs, 8'h0A);

        // Release then press again inside the window
        wr_en = 0; prog_n = 1;
        @(negedge clk);
        prog_n = 0; tb_drv = 18'h10007;
        @(negedge clk);
        #1;
        chk("R11 ae_ofs restart", ae_ofs, 8'h07);
        chk("R11 af_ofs restart", af_ofs, 8'h07);

        // First accepted write closes the window
        prog_n = 1; wr_en = 1; tb_drv = 18'h2ABCD;
        #1;
        chk("R2 push strobe", wr_stb, 1);
        chk("R2 push data", wr_data, 18'h2ABCD);
        @(negedge clk);
        wr_en = 0; prog_n = 0; tb_drv = 18'h00055;
        @(negedge clk);
        #1;
        chk("R10 ae_ofs after close", ae_ofs, 8'h07);
        chk("R10 af_ofs after close", af_ofs, 8'h07);
        @(negedge clk);
        #1;
        chk("R10 af_ofs second edge", af_ofs, 8'h07);

        // Exhaustive sweep of the control inputs
        for (int v = 0; v < 256; v++) begin
            logic e_oe, e_wr, e_rd;
            @(negedge clk);
            cs_n = v[0]; wr_sel = v[1]; wr_en = v[2]; rd_en = v[3];
            in_ready = v[4]; out_ready = v[5]; prog_n = v[6];
            rd_data = v[7] ? (18'h2A5A5 ^ 18'(v)) : (18'h15A5A + 18'(v));
            tb_drv = 18'h30000 | 18'(v * 3);
            tb_drv_en = v[1];
            #1;
            e_oe = !v[0] && !v[1];
            e_wr = !v[0] && v[1] && v[2] && v[4] && v[6];
            e_rd = !v[0] && !v[1] && v[3] && v[5];
            chk("R1 bus_oe", bus_oe, e_oe);
            if (e_oe) chk("R1 bus carries rd_data", bus_w, rd_data);
            if (v[1]) chk("R1 bus not driven by block", bus_w, tb_drv);
            if (!v[6]) chk("R6 push blocked", wr_stb, e_wr);
            else       chk("R2 push strobe", wr_stb, e_wr);
            if (e_wr) chk("R2 push data", wr_data, tb_drv);
            chk("R3 pop strobe", rd_stb, e_rd);
            if (v[0]) chk("R4 deselected idle", {wr_stb, rd_stb, bus_oe}, 0);
            chk("R5 exclusive strobes", wr_stb & rd_stb, 0);
        end
        @(negedge clk);
        #1;
        chk("R10 ae_ofs after sweep", ae_ofs, 8'h07);
        chk("R10 af_ofs after sweep", af_ofs, 8'h07);

        // Reset again
        cs_n = 1; prog_n = 1; wr_en = 0; tb_drv_en = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        chk("R12 ae_ofs default", ae_ofs, 128);
        chk("R12 af_ofs default", af_ofs, 128);
        cs_n = 0; wr_sel = 1; prog_n = 0; tb_drv = 18'h00020; tb_drv_en = 1;
        @(negedge clk);
        #1;
        chk("R12 ae_ofs reprogram", ae_ofs, 8'h20);
        chk("R12 af_ofs reprogram", af_ofs, 8'h20);

        finish_run();
    end
endmodule